// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupt Detection

This block controls a port of up to 32 general-purpose pins through a small 32-bit register bus. Software writes an output data word and a per-pin drive-enable word, and it can also set or clear single output bits without a read-modify-write. Input pins pass through a two-flop synchronizer, and software can read the synchronized values back. Pull and bypass settings are held as plain storage for logic elsewhere.

Each pin can raise an interrupt. A type bit chooses level or edge sensing. A polarity bit chooses the active sense, and a both-edges bit makes an edge-mode pin fire on either transition. Edge events are latched until software writes a one to the matching bit of a clear strobe. Level status follows the pin. A mask word hides pins from the masked status and from the single combined interrupt line.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset, pin_out, pin_oe and irq are 0, and every readable register returns 0.
- R2: A write to offset 0x00 sets pin_out, and a write to 0x08 sets pin_oe (1 = drive). Both read back and both appear after the write edge.
- R3: Writing offset 0x10 sets the output bits that are 1 in the data. Writing 0x14 clears them. Bits written as 0 keep their value, and both offsets read as 0.
- R4: Offset 0x04 returns pin_in through a two-flop synchronizer. A read sampled at the second edge after a pin change still returns the old value, and a read sampled at the fourth edge returns the new one.
- R5: With type bit 1 (offset 0x34), raw status at 0x24 follows the active level. Polarity bit 0 (offset 0x3C) means high is active and 1 means low is active. A level pin is not latched.
- R6: With type bit 0, polarity 0 detects rising edges and polarity 1 detects falling edges. Edge status stays set until it is cleared.
- R7: With both-edge bit 1 (offset 0x38) in edge mode, rising and falling transitions both set status, whatever the polarity bit holds.
- R8: A pin whose enable bit (offset 0x20) is 0 sets no status, and enabling it later does not report an earlier edge.
- R9: Writing 1 to a bit of offset 0x30 clears that pin's latched edge status. Bits written as 0 leave status unchanged. The offset reads as 0.
- R10: Masked status at 0x28 equals raw status AND NOT the mask at 0x2C (1 = suppress).
- R11: irq is the OR of the masked status bits, registered one clock after raw status or mask changes.
- R12: Offsets 0x0C, 0x18 and 0x1C are read/write storage with no effect on pin_out, pin_oe or irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address; low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one edge after the request |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output data |
| pin_oe | output | NPINS | Per-pin drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes take effect on the edge that samples them, and read data lands on the edge that samples the read request. The bench therefore drives requests at falling edges and checks at the next falling edge. A pin change reaches raw status at the third rising edge, after two synchronizer flops and the history flop, and reaches irq at the fourth. After a pin change the bench waits four falling edges before it reads or checks irq. The one-cycle lag of irq behind a clear or mask write is checked exactly: irq still holds the old value on the first falling edge after the write, and the new value on the second. The synchronizer delay on the data-in read path is checked the same way, with one read that still sees the old value and a later read that sees the new one.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int OFF_DOUT  = 'h00;
  localparam int OFF_DIN   = 'h04;
  localparam int OFF_DIR   = 'h08;
  localparam int OFF_BYP   = 'h0C;
  localparam int OFF_SET   = 'h10;
  localparam int OFF_CLR   = 'h14;
  localparam int OFF_PEN   = 'h18;
  localparam int OFF_PTYP  = 'h1C;
  localparam int OFF_IEN   = 'h20;
  localparam int OFF_RAW   = 'h24;
  localparam int OFF_MSKD  = 'h28;
  localparam int OFF_IMASK = 'h2C;
  localparam int OFF_ICLR  = 'h30;
  localparam int OFF_TRIG  = 'h34;
  localparam int OFF_BOTH  = 'h38;
  localparam int OFF_POL   = 'h3C;
  localparam int BUS_W     = 32;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpx_detect.sv
module gpx_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] lvl_mode,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ack,
  output logic [W-1:0] raw
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit, st_q;
    assign rise = cur[i] & ~prev[i];
    assign fall = ~cur[i] & prev[i];
    assign hit  = both[i] ? (rise | fall) : (pol[i] ? fall : rise);

    always_ff @(posedge clk) begin
      if (rst)
        st_q <= 1'b0;
      else if (lvl_mode[i])
        st_q <= en[i] & (cur[i] ^ pol[i]);
      else
        st_q <= (st_q & ~ack[i]) | (en[i] & hit);
    end

    assign raw[i] = st_q;
  end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [W-1:0]     din,
  input  logic [W-1:0]     raw,
  output logic [W-1:0]     dout,
  output logic [W-1:0]     dir,
  output logic [W-1:0]     ien,
  output logic [W-1:0]     imask,
  output logic [W-1:0]     trig,
  output logic [W-1:0]     both,
  output logic [W-1:0]     pol,
  output logic [W-1:0]     ack
);
  logic [AW-1:0] a_w;
  logic          wr, rd;
  logic [W-1:0]  wd;
  logic [W-1:0]  dout_q, dir_q, byp_q, pen_q, ptyp_q;
  logic [W-1:0]  ien_q, imask_q, trig_q, both_q, pol_q;
  logic [W-1:0]  rsel;
  logic [BUS_W-1:0] rext, rdata_q;

  assign a_w = {bus_addr[AW-1:2], 2'b00};
  assign wr  = bus_en & bus_we;
  assign rd  = bus_en & ~bus_we;
  assign wd  = bus_wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= '0;
      byp_q   <= '0;
      pen_q   <= '0;
      ptyp_q  <= '0;
      ien_q   <= '0;
      imask_q <= '0;
      trig_q  <= '0;
      both_q  <= '0;
      pol_q   <= '0;
    end else if (wr) begin
      case (a_w)
        AW'(OFF_DOUT):  dout_q  <= wd;
        AW'(OFF_SET):   dout_q  <= dout_q | wd;
        AW'(OFF_CLR):   dout_q  <= dout_q & ~wd;
        AW'(OFF_DIR):   dir_q   <= wd;
        AW'(OFF_BYP):   byp_q   <= wd;
        AW'(OFF_PEN):   pen_q   <= wd;
        AW'(OFF_PTYP):  ptyp_q  <= wd;
        AW'(OFF_IEN):   ien_q   <= wd;
        AW'(OFF_IMASK): imask_q <= wd;
        AW'(OFF_TRIG):  trig_q  <= wd;
        AW'(OFF_BOTH):  both_q  <= wd;
        AW'(OFF_POL):   pol_q   <= wd;
        default: ;
      endcase
    end
  end

  // Acknowledge strobe: live only in the cycle of the write.
  assign ack = (wr && a_w == AW'(OFF_ICLR)) ? wd : '0;

  always_comb begin
    case (a_w)
      AW'(OFF_DOUT):  rsel = dout_q;
      AW'(OFF_DIN):   rsel = din;
      AW'(OFF_DIR):   rsel = dir_q;
      AW'(OFF_BYP):   rsel = byp_q;
      AW'(OFF_PEN):   rsel = pen_q;
      AW'(OFF_PTYP):  rsel = ptyp_q;
      AW'(OFF_IEN):   rsel = ien_q;
      AW'(OFF_RAW):   rsel = raw;
      AW'(OFF_MSKD):  rsel = raw & ~imask_q;
      AW'(OFF_IMASK): rsel = imask_q;
      AW'(OFF_TRIG):  rsel = trig_q;
      AW'(OFF_BOTH):  rsel = both_q;
      AW'(OFF_POL):   rsel = pol_q;
      default:        rsel = '0;
    endcase
    rext = '0;
    rext[W-1:0] = rsel;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd)
      rdata_q <= rext;
  end

  assign bus_rdata = rdata_q;
  assign dout  = dout_q;
  assign dir   = dir_q;
  assign ien   = ien_q;
  assign imask = imask_q;
  assign trig  = trig_q;
  assign both  = both_q;
  assign pol   = pol_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpx_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [NPINS-1:0] cur_s, prev_s, raw_q;
  logic [NPINS-1:0] en_q, mask_q, typ_q, both_q, pol_q, ack_s;
  logic             irq_q;

  gpx_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .cur(cur_s), .prev(prev_s)
  );

  gpx_regs #(.W(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(cur_s), .raw(raw_q),
    .dout(pin_out), .dir(pin_oe),
    .ien(en_q), .imask(mask_q), .trig(typ_q), .both(both_q), .pol(pol_q),
    .ack(ack_s)
  );

  gpx_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst(rst), .cur(cur_s), .prev(prev_s),
    .en(en_q), .lvl_mode(typ_q), .both(both_q), .pol(pol_q),
    .ack(ack_s), .raw(raw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_q & ~mask_q);
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk
  import gpx_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_en,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] raw,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] typ
);
  logic [AW-1:0] a_w;
  logic          wr;
  assign a_w = {bus_addr[AW-1:2], 2'b00};
  assign wr  = bus_en & bus_we;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == 1'b0 && pin_oe == '0 && pin_out == '0));

  a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
    (wr && a_w == AW'(OFF_SET)) |=>
      ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  a_r3_clr_bits: assert property (@(posedge clk) disable iff (rst)
    (wr && a_w == AW'(OFF_CLR)) |=>
      ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

  a_r6_edge_held: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (($past(raw) & ~$past(typ) & ~raw) == '0));

  a_r8_no_detect_off: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ((raw & ~$past(raw) & ~$past(typ) & ~$past(en)) == '0));

  a_r11_irq_rises: assert property (@(posedge clk) disable iff (rst)
    ((raw & ~mask) != '0) |=> irq);

  a_r11_irq_falls: assert property (@(posedge clk) disable iff (rst)
    ((raw & ~mask) == '0) |=> !irq);
endmodule

bind gpio_irq_port gpx_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .raw(raw_q), .mask(mask_q), .en(en_q), .typ(typ_q)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  localparam int N = 32;
  localparam logic [7:0] A_DOUT = 8'h00, A_DIN = 8'h04, A_DIR = 8'h08, A_BYP = 8'h0C,
                         A_SET = 8'h10, A_CLR = 8'h14, A_PEN = 8'h18, A_PTY = 8'h1C,
                         A_IEN = 8'h20, A_RAW = 8'h24, A_MSK = 8'h28, A_IMK = 8'h2C,
                         A_ICL = 8'h30, A_TRG = 8'h34, A_BTH = 8'h38, A_POL = 8'h3C;

  localparam int NV = 11;
  localparam logic [7:0]  V_ADDR [NV] = '{8'h00, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h2C,
                                          8'h34, 8'h38, 8'h3C, 8'h30, 8'h10};
  localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_0F0F, 32'h0000_FFFF, 32'h1357_9BDF,
                                          32'hFFFF_0000, 32'h0F0F_F0F0, 32'h8000_0001,
                                          32'h0000_00FF, 32'h00FF_0000, 32'h1111_1111,
                                          32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [31:0] V_EXP  [NV] = '{32'hA5A5_0F0F, 32'h0000_FFFF, 32'h1357_9BDF,
                                          32'hFFFF_0000, 32'h0F0F_F0F0, 32'h8000_0001,
                                          32'h0000_00FF, 32'h00FF_0000, 32'h1111_1111,
                                          32'h0000_0000, 32'h0000_0000};
  localparam int          V_REQ  [NV] = '{2, 2, 12, 12, 12, 10, 5, 7, 6, 9, 3};

  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pins = '0, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.NPINS(N), .AW(8)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    pins = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // R1 reset state
    chk("R1 pin_out", 32'(pin_out), 32'h0);
    chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(A_RAW, r); chk("R1 raw", r, 32'h0);
    rd(A_POL, r); chk("R1 pol", r, 32'h0);

    // Table: write then read back
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], r);
      checks++;
      if (r !== V_EXP[i]) begin
        errors++;
        $display("FAIL R%0d table entry %0d actual=%h expected=%h", V_REQ[i], i, r, V_EXP[i]);
      end
    end
    chk("R12 table leaves irq low", 32'(irq), 32'h0);

    // R2 output data and direction
    do_reset();
    wr(A_DOUT, 32'h1234_5678); chk("R2 pin_out", 32'(pin_out), 32'h1234_5678);
    wr(A_DIR, 32'hF0F0_000F);  chk("R2 pin_oe", 32'(pin_oe), 32'hF0F0_000F);

    // R3 set / clear strobes
    wr(A_SET, 32'h0000_00F0); chk("R3 set", 32'(pin_out), 32'h1234_56F8);
    wr(A_CLR, 32'h0000_0018); chk("R3 clear", 32'(pin_out), 32'h1234_56E0);
    rd(A_CLR, r); chk("R3 clear reads 0", r, 32'h0);

    // R4 synchronizer latency on data in
    @(negedge clk); pins = 32'hCAFE_0000;
    rd(A_DIN, r); chk("R4 din early old", r, 32'h0);
    rd(A_DIN, r); chk("R4 din late new", r, 32'hCAFE_0000);

    // R5 level mode
    do_reset();
    wr(A_IEN, 32'h1); wr(A_TRG, 32'h1);
    pins[0] = 1'b1; settle();
    chk("R5 level irq high", 32'(irq), 32'h1);
    rd(A_RAW, r); chk("R5 level active high", r, 32'h1);
    pins[0] = 1'b0; settle();
    rd(A_RAW, r); chk("R5 level not latched", r, 32'h0);
    chk("R5 irq drops", 32'(irq), 32'h0);
    wr(A_POL, 32'h1); repeat (2) @(negedge clk);
    rd(A_RAW, r); chk("R5 active low", r, 32'h1);

    // R6 edge mode
    do_reset();
    wr(A_IEN, 32'h2);
    pins[1] = 1'b1; settle();
    rd(A_RAW, r); chk("R6 rising sets", r, 32'h2);
    pins[1] = 1'b0; settle();
    rd(A_RAW, r); chk("R6 latched", r, 32'h2);
    wr(A_ICL, 32'h2);
    rd(A_RAW, r); chk("R6 cleared", r, 32'h0);
    wr(A_POL, 32'h2);
    pins[1] = 1'b1; settle();
    rd(A_RAW, r); chk("R6 falling ignores rise", r, 32'h0);
    pins[1] = 1'b0; settle();
    rd(A_RAW, r); chk("R6 falling sets", r, 32'h2);

    // R7 both edges, polarity ignored
    wr(A_ICL, 32'h2);
    wr(A_IEN, 32'h6); wr(A_BTH, 32'h4); wr(A_POL, 32'h6);
    pins[2] = 1'b1; settle();
    rd(A_RAW, r); chk("R7 both rise", r & 32'h4, 32'h4);
    wr(A_ICL, 32'h4);
    pins[2] = 1'b0; settle();
    rd(A_RAW, r); chk("R7 both fall", r & 32'h4, 32'h4);

    // R9 selective clear
    pins[1] = 1'b1; settle();
    pins[1] = 1'b0; settle();
    rd(A_RAW, r); chk("R9 two latched", r, 32'h6);
    wr(A_ICL, 32'h2);
    rd(A_RAW, r); chk("R9 zero bits kept", r, 32'h4);

    // R11 irq lags status by one edge
    chk("R11 irq set", 32'(irq), 32'h1);
    wr(A_ICL, 32'h4);
    chk("R11 irq one cycle lag", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R11 irq cleared", 32'(irq), 32'h0);

    // R10 mask
    pins[2] = 1'b1; settle();
    chk("R10 irq before mask", 32'(irq), 32'h1);
    wr(A_IMK, 32'h4);
    @(negedge clk);
    chk("R10 masked irq low", 32'(irq), 32'h0);
    rd(A_MSK, r); chk("R10 masked status", r, 32'h0);
    rd(A_RAW, r); chk("R10 raw unaffected", r, 32'h4);
    wr(A_IMK, 32'h0);
    @(negedge clk);
    chk("R10 unmask irq", 32'(irq), 32'h1);
    rd(A_MSK, r); chk("R10 masked shows", r, 32'h4);

    // R8 disabled pin ignores edges
    do_reset();
    pins[3] = 1'b1; settle();
    rd(A_RAW, r); chk("R8 disabled no status", r, 32'h0);
    wr(A_IEN, 32'h8); repeat (2) @(negedge clk);
    rd(A_RAW, r); chk("R8 no late report", r, 32'h0);
    chk("R8 irq low", 32'(irq), 32'h0);

    // R12 storage has no side effect
    do_reset();
    wr(A_DOUT, 32'h55); wr(A_DIR, 32'hF0);
    wr(A_BYP, 32'hFFFF_FFFF); wr(A_PEN, 32'hFFFF_FFFF); wr(A_PTY, 32'hFFFF_FFFF);
    chk("R12 pin_out kept", 32'(pin_out), 32'h55);
    chk("R12 pin_oe kept", 32'(pin_oe), 32'hF0);
    chk("R12 irq kept", 32'(irq), 32'h0);
    rd(A_PTY, r); chk("R12 readback", r, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule